// File: doc/BRIEF.md
# Exception Entry Register Update Unit

This unit applies the control-state changes a 32-bit RISC core with branch delay slots must make when it accepts an exception. The pipeline presents one request per exception. The request carries a 5-bit cause code, the PC of the faulting instruction, a flag that says whether that instruction sits in a delay slot, the faulting virtual address, a coprocessor number, and a flag that marks a translation-refill miss.

In the clock edge that samples the request, the unit updates six registers: the status word, the cause word, the exception PC, the bad-address register, the shadow-set control word and the vector base. In the same edge it registers the handler address. That address is chosen from the cause code and from the status and cause bits as they stood before the entry. The handler address is held on `handler_pc`, and `redirect` pulses high for one cycle to tell the fetch stage to jump there.

A small register port lets software-visible logic read and write the six words. Reads are combinational. Writes land on the next edge.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The shadow-set control word has three fields: current set in bits 3:0, previous set in bits 7:4, exception set in bits 11:8. On entry, the previous field takes the old current value and the current field takes the exception value, but only when status bit 1 (EXL) and status bit 22 (BEV) were both 0 before entry. Otherwise the word is left unchanged.
- R2: Every entry sets status bit 1, even when it is already 1. No other status bit changes.
- R3: If the request is in a delay slot, the exception PC becomes the faulting PC minus 4 and cause bit 31 is set. Otherwise the exception PC becomes the faulting PC and cause bit 31 is cleared.
- R4: On entry, cause bits 6:2 take the 5-bit code. Cause bits outside 31, 29:28 and 6:2 keep their value.
- R5: Cause bits 29:28 take the coprocessor number when the code is 11 (coprocessor unusable). For any other code they are cleared.
- R6: Codes with no special vector go to vector base + 0x180. One cycle after the request, `redirect` is high for exactly one cycle, and `handler_pc` holds the address until the next entry.
- R7: When the refill flag is set with code 2 or 3, the handler is vector base + 0x000 if EXL was 0 before entry, and vector base + 0x180 if EXL was already 1.
- R8: Code 0 (interrupt) goes to vector base + 0x200 when cause bit 23 is 1, and to vector base + 0x180 otherwise.
- R9: Code 12 (arithmetic overflow) goes to the fixed address 0xBFC00200 when status bit 22 is 1. Otherwise it goes to vector base + 0x180.
- R10: The bad-address register takes the request address only for codes 1 to 5 (translation and address-error faults). For all other codes it keeps its value.
- R11: Register select codes are: 0 status, 1 cause, 2 exception PC, 3 bad address, 4 shadow control, 5 vector base. Codes 6 and 7 read as 0 and ignore writes. Reset values are: status 0x00400000, vector base 0x80000000, all others 0. A port write made in the same cycle as a request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Exception request this cycle |
| exc_code | input | 5 | Exception cause code |
| exc_refill | input | 1 | Request is a translation refill miss |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_slot | input | 1 | Faulting instruction is in a delay slot |
| exc_badva | input | 32 | Faulting virtual address |
| exc_cop_id | input | 2 | Coprocessor number for code 11 |
| reg_sel | input | 3 | Register port select |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_wr_data | input | 32 | Register port write data |
| reg_rd_data | output | 32 | Register port read data (combinational) |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| handler_pc | output | 32 | Handler address of the latest entry |

## Verification
The bench builds the unit with its default parameters. These are: 4-bit shadow-set fields, a vector base of 0x80000000 out of reset, and a reset status word with BEV set. Because BEV is set after reset, the fixed-address overflow vector and the held shadow word are both reachable before software touches anything. Writing the status and cause words through the port then brings up the other paths: the refill split on prior EXL, the interrupt split on bit 23, and the shadow rotation.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int WORD_W  = 32;
    localparam int CODE_W  = 5;
    localparam int COP_W   = 2;
    localparam int SEL_W   = 3;

    // bit positions decoded by software and by the interrupt logic
    localparam int BIT_EXL = 1;
    localparam int BIT_BEV = 22;
    localparam int BIT_IV  = 23;
    localparam int BIT_BD  = 31;
    localparam int CE_LO   = 28;
    localparam int CODE_LO = 2;

    localparam logic [CODE_W-1:0] EXC_INT  = 5'd0;
    localparam logic [CODE_W-1:0] EXC_MOD  = 5'd1;
    localparam logic [CODE_W-1:0] EXC_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] EXC_TLBS = 5'd3;
    localparam logic [CODE_W-1:0] EXC_ADES = 5'd5;
    localparam logic [CODE_W-1:0] EXC_CPU  = 5'd11;
    localparam logic [CODE_W-1:0] EXC_OVF  = 5'd12;

    localparam logic [WORD_W-1:0] OFF_GEN = 32'h0000_0180;
    localparam logic [WORD_W-1:0] OFF_INT = 32'h0000_0200;

    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CAUSE  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_EPC    = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BADVA  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_SHADOW = 3'd4;
    localparam logic [SEL_W-1:0] SEL_EBASE  = 3'd5;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t status;
        word_t cause;
        word_t epc;
        word_t badva;
        word_t shadow;
        word_t ebase;
        word_t hpc;
        logic  redir;
    } entry_state_t;

    function automatic logic is_addr_fault(input logic [CODE_W-1:0] code);
        return (code >= EXC_MOD) && (code <= EXC_ADES);
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter logic [WORD_W-1:0] BOOT_OVF_VEC = 32'hBFC0_0200
) (
    input  logic [CODE_W-1:0] code,
    input  logic              refill,
    input  logic              exl_prior,
    input  logic              bev_prior,
    input  logic              iv_prior,
    input  word_t             ebase,
    output word_t             vec
);
    logic refill_kind;

    always_comb begin
        refill_kind = refill && ((code == EXC_TLBL) || (code == EXC_TLBS));
        if (refill_kind) begin
            vec = exl_prior ? (ebase + OFF_GEN) : ebase;
        end else if (code == EXC_INT) begin
            vec = iv_prior ? (ebase + OFF_INT) : (ebase + OFF_GEN);
        end else if ((code == EXC_OVF) && bev_prior) begin
            vec = BOOT_OVF_VEC;
        end else begin
            vec = ebase + OFF_GEN;
        end
    end
endmodule

// File: rtl/exc_cause_merge.sv
module exc_cause_merge
    import exc_entry_pkg::*;
(
    input  word_t             cause_old,
    input  logic [CODE_W-1:0] code,
    input  logic              in_slot,
    input  logic [COP_W-1:0]  cop_id,
    input  word_t             pc,
    output word_t             cause_new,
    output word_t             epc_new
);
    always_comb begin
        cause_new                       = cause_old;
        cause_new[BIT_BD]               = in_slot;
        cause_new[CE_LO +: COP_W]       = (code == EXC_CPU) ? cop_id : '0;
        cause_new[CODE_LO +: CODE_W]    = code;
        epc_new = in_slot ? (pc - 32'd4) : pc;
    end
endmodule

// File: rtl/exc_shadow_rot.sv
module exc_shadow_rot
    import exc_entry_pkg::*;
#(
    parameter int SET_W = 4
) (
    input  word_t shadow_old,
    input  logic  rotate,
    output word_t shadow_new
);
    localparam int CUR_LO  = 0;
    localparam int PREV_LO = SET_W;
    localparam int EXC_LO  = 2 * SET_W;

    always_comb begin
        shadow_new = shadow_old;
        if (rotate) begin
            shadow_new[PREV_LO +: SET_W] = shadow_old[CUR_LO +: SET_W];
            shadow_new[CUR_LO  +: SET_W] = shadow_old[EXC_LO +: SET_W];
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                SET_W        = 4,
    parameter logic [WORD_W-1:0] RESET_STATUS = 32'h0040_0000,
    parameter logic [WORD_W-1:0] RESET_EBASE  = 32'h8000_0000,
    parameter logic [WORD_W-1:0] BOOT_OVF_VEC = 32'hBFC0_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_refill,
    input  logic [WORD_W-1:0] exc_pc,
    input  logic              exc_in_slot,
    input  logic [WORD_W-1:0] exc_badva,
    input  logic [COP_W-1:0]  exc_cop_id,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic [WORD_W-1:0] reg_rd_data,
    output logic              redirect,
    output logic [WORD_W-1:0] handler_pc
);
    entry_state_t st_d, st_q;
    word_t        vec_w, cause_w, epc_w, shadow_w;
    logic         may_rotate;

    assign may_rotate = !st_q.status[BIT_EXL] && !st_q.status[BIT_BEV];

    exc_vector_sel #(.BOOT_OVF_VEC(BOOT_OVF_VEC)) u_vec (
        .code      (exc_code),
        .refill    (exc_refill),
        .exl_prior (st_q.status[BIT_EXL]),
        .bev_prior (st_q.status[BIT_BEV]),
        .iv_prior  (st_q.cause[BIT_IV]),
        .ebase     (st_q.ebase),
        .vec       (vec_w)
    );

    exc_cause_merge u_cause (
        .cause_old (st_q.cause),
        .code      (exc_code),
        .in_slot   (exc_in_slot),
        .cop_id    (exc_cop_id),
        .pc        (exc_pc),
        .cause_new (cause_w),
        .epc_new   (epc_w)
    );

    exc_shadow_rot #(.SET_W(SET_W)) u_shadow (
        .shadow_old (st_q.shadow),
        .rotate     (may_rotate),
        .shadow_new (shadow_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        if (exc_valid) begin
            st_d.status          = st_q.status;
            st_d.status[BIT_EXL] = 1'b1;
            st_d.cause           = cause_w;
            st_d.epc             = epc_w;
            st_d.shadow          = shadow_w;
            st_d.hpc             = vec_w;
            st_d.redir           = 1'b1;
            if (is_addr_fault(exc_code)) begin
                st_d.badva = exc_badva;
            end
        end else if (reg_wr_en) begin
            case (reg_sel)
                SEL_STATUS: st_d.status = reg_wr_data;
                SEL_CAUSE:  st_d.cause  = reg_wr_data;
                SEL_EPC:    st_d.epc    = reg_wr_data;
                SEL_BADVA:  st_d.badva  = reg_wr_data;
                SEL_SHADOW: st_d.shadow = reg_wr_data;
                SEL_EBASE:  st_d.ebase  = reg_wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.status <= RESET_STATUS;
            st_q.ebase  <= RESET_EBASE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_STATUS: reg_rd_data = st_q.status;
            SEL_CAUSE:  reg_rd_data = st_q.cause;
            SEL_EPC:    reg_rd_data = st_q.epc;
            SEL_BADVA:  reg_rd_data = st_q.badva;
            SEL_SHADOW: reg_rd_data = st_q.shadow;
            SEL_EBASE:  reg_rd_data = st_q.ebase;
            default:    reg_rd_data = '0;
        endcase
    end

    assign redirect   = st_q.redir;
    assign handler_pc = st_q.hpc;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int SET_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic [WORD_W-1:0] exc_pc,
    input logic              exc_in_slot,
    input logic              redirect,
    input logic [WORD_W-1:0] status_q,
    input logic [WORD_W-1:0] cause_q,
    input logic [WORD_W-1:0] epc_q,
    input logic [WORD_W-1:0] badva_q,
    input logic [WORD_W-1:0] shadow_q
);
    p_exl_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> status_q[BIT_EXL]);

    p_epc_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_in_slot) |=> (cause_q[BIT_BD] && (epc_q == $past(exc_pc) - 32'd4)));

    p_epc_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_in_slot) |=> (!cause_q[BIT_BD] && (epc_q == $past(exc_pc))));

    p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (cause_q[CODE_LO +: CODE_W] == $past(exc_code)));

    p_pulse_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> redirect);

    p_pulse_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> !redirect);

    p_badva_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !is_addr_fault(exc_code)) |=> $stable(badva_q));

    p_shadow_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && (status_q[BIT_EXL] || status_q[BIT_BEV])) |=> $stable(shadow_q));

    p_shadow_rot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !status_q[BIT_EXL] && !status_q[BIT_BEV]) |=>
        (shadow_q[SET_W +: SET_W] == $past(shadow_q[0 +: SET_W])));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.SET_W(SET_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code),
    .exc_pc      (exc_pc),
    .exc_in_slot (exc_in_slot),
    .redirect    (redirect),
    .status_q    (st_q.status),
    .cause_q     (st_q.cause),
    .epc_q       (st_q.epc),
    .badva_q     (st_q.badva),
    .shadow_q    (st_q.shadow)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_refill = 1'b0;
    logic [31:0] exc_pc = '0;
    logic        exc_in_slot = 1'b0;
    logic [31:0] exc_badva = '0;
    logic [1:0]  exc_cop_id = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        redirect;
    logic [31:0] handler_pc;

    int total = 0;
    int bad = 0;
    string tag = "R11";

    // reference state
    logic [31:0] m_status = 32'h0040_0000;
    logic [31:0] m_cause = 0, m_epc = 0, m_badva = 0, m_shadow = 0;
    logic [31:0] m_ebase = 32'h8000_0000, m_hpc = 0;
    logic        m_redir = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_refill(exc_refill), .exc_pc(exc_pc), .exc_in_slot(exc_in_slot),
        .exc_badva(exc_badva), .exc_cop_id(exc_cop_id), .reg_sel(reg_sel),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .redirect(redirect), .handler_pc(handler_pc)
    );

    function automatic logic [31:0] m_read(input logic [2:0] s);
        case (s)
            3'd0: return m_status;
            3'd1: return m_cause;
            3'd2: return m_epc;
            3'd3: return m_badva;
            3'd4: return m_shadow;
            3'd5: return m_ebase;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] cur, ex;
        if (exc_valid) begin
            if (exc_refill && (exc_code == 2 || exc_code == 3))
                m_hpc = m_status[1] ? m_ebase + 32'h180 : m_ebase;
            else if (exc_code == 0)
                m_hpc = m_cause[23] ? m_ebase + 32'h200 : m_ebase + 32'h180;
            else if (exc_code == 12 && m_status[22])
                m_hpc = 32'hBFC0_0200;
            else
                m_hpc = m_ebase + 32'h180;
            if (!m_status[1] && !m_status[22]) begin
                cur = m_shadow & 32'hF;
                ex  = (m_shadow >> 8) & 32'hF;
                m_shadow = (m_shadow & ~32'hFF) | (cur << 4) | ex;
            end
            if (exc_code >= 1 && exc_code <= 5) m_badva = exc_badva;
            m_status = m_status | 32'h2;
            m_cause = m_cause & ~32'hB000_007C;
            if (exc_in_slot) m_cause = m_cause | 32'h8000_0000;
            if (exc_code == 11) m_cause = m_cause | (32'(exc_cop_id) << 28);
            m_cause = m_cause | (32'(exc_code) << 2);
            m_epc = exc_in_slot ? exc_pc - 4 : exc_pc;
            m_redir = 1'b1;
        end else begin
            m_redir = 1'b0;
            if (reg_wr_en) begin
                case (reg_sel)
                    3'd0: m_status = reg_wr_data;
                    3'd1: m_cause  = reg_wr_data;
                    3'd2: m_epc    = reg_wr_data;
                    3'd3: m_badva  = reg_wr_data;
                    3'd4: m_shadow = reg_wr_data;
                    3'd5: m_ebase  = reg_wr_data;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(redirect === m_redir, "redirect", 32'(redirect), 32'(m_redir));
        chk(handler_pc === m_hpc, "handler_pc", handler_pc, m_hpc);
        chk(reg_rd_data === m_read(reg_sel), "rd_data", reg_rd_data, m_read(reg_sel));
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        reg_sel = s; reg_wr_en = 1'b1; reg_wr_data = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic read_all();
        for (int s = 0; s < 8; s++) begin
            reg_sel = 3'(s);
            tick();
        end
    endtask

    task automatic take(input logic [4:0] code, input logic refill, input logic [31:0] pc,
                        input logic slot, input logic [31:0] va, input logic [1:0] cop);
        exc_valid = 1'b1; exc_code = code; exc_refill = refill; exc_pc = pc;
        exc_in_slot = slot; exc_badva = va; exc_cop_id = cop;
        tick();
        exc_valid = 1'b0; exc_refill = 1'b0; exc_in_slot = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R11"; read_all();                               // reset values
        tag = "R9";  take(5'd12, 0, 32'h1000, 0, 32'h0, 0);    // BEV=1 at reset: fixed vector
        tag = "R1";  read_all();                               // shadow held while BEV=1
        wr(3'd0, 32'h0); wr(3'd4, 32'h0000_0502);
        tag = "R10"; take(5'd4, 0, 32'h0000_0100, 0, 32'h0000_0123, 0);
        tag = "R1";  read_all();                               // rotated: 0x525
        tag = "R7";  take(5'd2, 1, 32'h0000_0200, 1, 32'h0000_0777, 0); // EXL=1 -> +0x180
        tag = "R3";  read_all();
        tag = "R2";  take(5'd10, 0, 32'h0000_0300, 0, 32'h0, 0); // EXL already set
        read_all();
        wr(3'd0, 32'h0);
        tag = "R7";  take(5'd3, 1, 32'h0000_0400, 0, 32'h0000_0888, 0); // EXL=0 -> base
        read_all();
        wr(3'd0, 32'h0); wr(3'd1, 32'h0080_0000);
        tag = "R8";  take(5'd0, 0, 32'h0000_0500, 0, 32'hFFFF_FFFF, 0);
        tag = "R10"; read_all();
        wr(3'd1, 32'h0);
        tag = "R8";  take(5'd0, 0, 32'h0000_0504, 0, 32'h0, 0);
        wr(3'd0, 32'h0);
        tag = "R9";  take(5'd12, 0, 32'h0000_0600, 0, 32'h0, 0); // BEV=0 -> +0x180
        tag = "R5";  take(5'd11, 0, 32'h0000_0700, 1, 32'h0, 2'd2);
        read_all();
        take(5'd10, 0, 32'h0000_0704, 0, 32'h0, 2'd3);
        read_all();
        tag = "R6";  wr(3'd5, 32'h9000_0000);
        take(5'd8, 0, 32'h0000_0800, 0, 32'h0, 0);
        take(5'd9, 0, 32'h0000_0804, 0, 32'h0, 0);           // back to back
        tick(); tick();
        tag = "R11";
        reg_sel = 3'd2; reg_wr_en = 1'b1; reg_wr_data = 32'hDEAD_BEEF;
        take(5'd1, 0, 32'h0000_0040, 0, 32'h0000_0044, 0);   // write dropped
        reg_wr_en = 1'b0;
        read_all();
        wr(3'd7, 32'h1234_5678); wr(3'd6, 32'hFFFF_FFFF);
        read_all();
        tag = "R4";  wr(3'd1, 32'h4F7F_FF83);
        take(5'd5, 0, 32'h0000_0900, 1, 32'h0000_0904, 0);
        read_all();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule